// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block watches the cache-line read requests that a first-level cache sends outward and spots runs of requests that walk through memory one 64-byte line at a time, either upward or downward. Once a run is established it asks for the line two steps further along the run, so that the data is already on its way when the demand stream gets there. Each tracked run is keyed by the 4 KiB page it lives in, and a prefetch target is never allowed to leave that page, because the next page may not be mapped or may map somewhere unrelated.

A small table holds four streams. A request to a page that no entry tracks claims the entry that was filled longest ago. Within an entry, a 64-bit record of lines already requested stops the same line from being prefetched twice for that stream. Prefetch addresses leave through a single holding register with a valid/ready handshake. While that register is full and not being drained, any newer prefetch is discarded.

Top module: `pfx_stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and no stream is tracked, so the first requests to any page produce no prefetch.
- R2: Three requests to lines L, L+1, L+2 of one page (line index = address bits 11:6, page = bits 31:12) cause, one clock edge after the third request, `pf_valid` high with `pf_addr` equal to the byte address of line L+4 in that page.
- R3: Three requests to lines L, L-1, L-2 of one page cause, one edge after the third request, a prefetch of line L-4 in that page.
- R4: No prefetch is produced without a triggering request. A stream whose run is broken by a step other than plus or minus one line (or by a reversal) produces none until two fresh unit steps in one direction have been seen.
- R5: A prefetch target below line 0 or above line 63 of the triggering page is suppressed. A target of exactly line 63 or line 0 is issued.
- R6: A stream entering a new page produces no prefetch there until three requests to that page form a run of its own.
- R7: A line already accepted as a prefetch for a stream is not issued again for that stream while the entry lives.
- R8: Four pages are tracked at once. A request to an untracked page replaces the entry allocated longest ago, and the replaced page loses its run.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_addr` holds its value and newer prefetches are discarded. With `pf_ready` high and nothing new, `pf_valid` falls at the next edge.
- R10: A repeated request to the stream's latest line leaves the stream unchanged and produces no prefetch.
- R11: `pf_addr` is always a line-aligned byte address (bits 5:0 zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A demand read request is present this cycle |
| req_addr | input | 32 | Byte address of the demand request |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | 32 | Line-aligned byte address to prefetch |
| pf_ready | input | 1 | The consumer takes the offered prefetch at this edge |

## Verification
A prefetch is due at the first clock edge that samples its triggering request, so the bench drives each request after a falling edge and reads `pf_valid` and `pf_addr` one nanosecond after the following rising edge. A held prefetch must still be on the outputs at every later edge until an edge sees `pf_ready` high, and the bench checks it at each such edge. Directed sequences check fixed line numbers at page edges, on eviction and on duplicates. A random phase with a fixed seed mixes unit steps, repeats, reversals, jumps, page switches and stalls, and compares every cycle against an expected-value model built from the requirements.

// File: rtl/pfx_pkg.sv
// Shared types for the stream prefetcher.
// Assumes: nothing beyond the direction encoding defined here.
package pfx_pkg;
    // Direction of a tracked stream; up means increasing line index.
    typedef enum logic {
        PFX_UP   = 1'b0,
        PFX_DOWN = 1'b1
    } pfx_dir_e;

    // Width of the per-stream run counter (values 0, 1, 2 are used).
    localparam int PFX_RUN_W = 2;
endpackage

// File: rtl/pfx_step_eval.sv
// Combinational evaluation of one demand request against the entry it
// selects: next run state, and the prefetch candidate line if the run is
// confirmed, the target stays inside the page and the line is not yet
// recorded as issued.
// Assumes: a miss is evaluated as a fresh allocation; DIST < 2**OFF_W.
module pfx_step_eval
    import pfx_pkg::*;
#(
    parameter int OFF_W = 6,
    parameter int DIST  = 2
) (
    input  logic                 hit,
    input  logic [OFF_W-1:0]     ent_last,
    input  pfx_dir_e             ent_dir,
    input  logic [PFX_RUN_W-1:0] ent_run,
    input  logic [(1<<OFF_W)-1:0] ent_bits,
    input  logic [OFF_W-1:0]     req_off,
    output logic [OFF_W-1:0]     nxt_last,
    output pfx_dir_e             nxt_dir,
    output logic [PFX_RUN_W-1:0] nxt_run,
    output logic                 cand_valid,
    output logic [OFF_W-1:0]     cand_off
);
    localparam int LINES = 1 << OFF_W;
    localparam logic [OFF_W+1:0] DIST_W  = (OFF_W+2)'(DIST);
    localparam logic [OFF_W+1:0] LINES_W = (OFF_W+2)'(LINES);

    logic     step_up, step_dn, same_line;
    pfx_dir_e step_dir;
    logic [OFF_W+1:0] tgt;
    logic     tgt_in_page;

    // Classify the request relative to the stream's latest line.
    always_comb begin
        step_up   = ({1'b0, ent_last} + 1'b1) == {1'b0, req_off};
        step_dn   = ({1'b0, req_off} + 1'b1) == {1'b0, ent_last};
        same_line = (req_off == ent_last);
        step_dir  = step_dn ? PFX_DOWN : PFX_UP;
    end

    // Next stream state for the selected (or newly allocated) entry.
    always_comb begin
        nxt_last = req_off;
        nxt_dir  = ent_dir;
        nxt_run  = '0;
        if (!hit) begin
            nxt_dir = PFX_UP;
        end else if (same_line) begin
            nxt_last = ent_last;
            nxt_run  = ent_run;
        end else if (step_up || step_dn) begin
            nxt_dir = step_dir;
            nxt_run = (ent_run != '0 && ent_dir == step_dir) ? 2'd2 : 2'd1;
        end
    end

    // Target line two ahead in the run direction, with the page bound.
    always_comb begin
        if (nxt_dir == PFX_UP) begin
            tgt         = {2'b00, req_off} + DIST_W;
            tgt_in_page = tgt < LINES_W;
        end else begin
            tgt         = {2'b00, req_off} - DIST_W;
            tgt_in_page = {2'b00, req_off} >= DIST_W;
        end
        cand_off   = tgt[OFF_W-1:0];
        cand_valid = hit && !same_line && (nxt_run == 2'd2) &&
                     tgt_in_page && !ent_bits[cand_off];
    end
endmodule

// File: rtl/pfx_stream_table.sv
// Table of tracked streams keyed by page tag. Looks up the request page,
// presents the matching entry, writes back the evaluated state and
// allocates over the entry filled longest ago on a miss.
// Assumes: at most one entry per page (guaranteed by allocate-on-miss);
// mark is only raised on a hit.
module pfx_stream_table
    import pfx_pkg::*;
#(
    parameter int N_STREAMS = 4,
    parameter int TAG_W     = 20,
    parameter int OFF_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [TAG_W-1:0]      req_page,
    input  logic [OFF_W-1:0]      nxt_last,
    input  pfx_dir_e              nxt_dir,
    input  logic [PFX_RUN_W-1:0]  nxt_run,
    input  logic                  mark,
    input  logic [OFF_W-1:0]      mark_off,
    output logic                  hit,
    output logic [OFF_W-1:0]      sel_last,
    output pfx_dir_e              sel_dir,
    output logic [PFX_RUN_W-1:0]  sel_run,
    output logic [(1<<OFF_W)-1:0] sel_bits
);
    localparam int LINES = 1 << OFF_W;
    localparam int IDX_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1;

    logic                 valid_q [N_STREAMS];
    logic [TAG_W-1:0]     page_q  [N_STREAMS];
    logic [OFF_W-1:0]     last_q  [N_STREAMS];
    pfx_dir_e             dir_q   [N_STREAMS];
    logic [PFX_RUN_W-1:0] run_q   [N_STREAMS];
    logic [LINES-1:0]     bits_q  [N_STREAMS];
    logic [IDX_W-1:0]     alloc_ptr;
    logic [N_STREAMS-1:0] match;
    logic [IDX_W-1:0]     hit_idx;
    logic [IDX_W-1:0]     wr_idx;

    // Per-entry page comparators.
    for (genvar g = 0; g < N_STREAMS; g++) begin : g_match
        assign match[g] = valid_q[g] && (page_q[g] == req_page);
    end

    // Encode the matching entry and select its fields.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit      = |match;
        sel_last = last_q[hit_idx];
        sel_dir  = dir_q[hit_idx];
        sel_run  = run_q[hit_idx];
        sel_bits = bits_q[hit_idx];
        wr_idx   = hit ? hit_idx : alloc_ptr;
    end

    // Write back stream state, allocate on miss, record accepted lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_ptr <= '0;
            for (int i = 0; i < N_STREAMS; i++) begin
                valid_q[i] <= 1'b0;
                page_q[i]  <= '0;
                last_q[i]  <= '0;
                dir_q[i]   <= PFX_UP;
                run_q[i]   <= '0;
                bits_q[i]  <= '0;
            end
        end else if (req_valid) begin
            last_q[wr_idx] <= nxt_last;
            dir_q[wr_idx]  <= nxt_dir;
            run_q[wr_idx]  <= nxt_run;
            if (!hit) begin
                valid_q[wr_idx] <= 1'b1;
                page_q[wr_idx]  <= req_page;
                bits_q[wr_idx]  <= '0;
                alloc_ptr <= (alloc_ptr == IDX_W'(N_STREAMS - 1)) ? '0 : alloc_ptr + 1'b1;
            end else if (mark) begin
                bits_q[wr_idx][mark_off] <= 1'b1;
            end
        end
    end

    // A page never sits in two entries at once.
    assert_one_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // Only a tracked stream can record an issued line.
    assert_mark_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mark |-> (req_valid && hit));

    // A page allocated on a miss is found by a request to it at the next edge.
    assert_alloc_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (req_valid && req_page == $past(req_page)) |-> hit);
endmodule

// File: rtl/pfx_issue_slot.sv
// One-deep holding register for prefetch addresses with valid/ready.
// Loads a candidate when empty or being drained; otherwise the candidate
// is discarded and not reported as accepted.
// Assumes: the consumer samples pf_addr when pf_valid and pf_ready are high.
module pfx_issue_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              accept
);
    // Candidate is taken only if the slot is free at this edge.
    assign accept = cand_valid && (!pf_valid || pf_ready);

    // Hold, replace or drain the offered prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else if (accept) begin
            pf_valid <= 1'b1;
            pf_addr  <= cand_addr;
        end else if (pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    // A stalled offer stays put.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    // A drained slot with nothing new goes empty.
    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !cand_valid) |=> !pf_valid);
endmodule

// File: rtl/pfx_stream_prefetcher.sv
// Stream prefetcher top. Splits each demand byte address into page tag and
// line-in-page index, runs the stream table and step evaluation in the
// request cycle, and registers any resulting prefetch in the issue slot.
// Assumes: one request per cycle; LINE_BYTES and PAGE_BYTES are powers of
// two with PAGE_BYTES > LINE_BYTES.
module pfx_stream_prefetcher
    import pfx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int N_STREAMS  = 4,
    parameter int DIST       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_ready
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int OFF_W  = PAGE_W - LINE_W;
    localparam int TAG_W  = ADDR_W - PAGE_W;
    localparam int LN_W   = ADDR_W - LINE_W;

    logic [TAG_W-1:0]       req_page;
    logic [OFF_W-1:0]       req_off;
    logic                   hit;
    logic [OFF_W-1:0]       sel_last, nxt_last, cand_off;
    pfx_dir_e               sel_dir, nxt_dir;
    logic [PFX_RUN_W-1:0]   sel_run, nxt_run;
    logic [(1<<OFF_W)-1:0]  sel_bits;
    logic                   cand_valid, accept;
    logic [ADDR_W-1:0]      cand_addr;

    // Address split and candidate byte address in the request's page.
    always_comb begin
        req_page  = req_addr[ADDR_W-1:PAGE_W];
        req_off   = req_addr[PAGE_W-1:LINE_W];
        cand_addr = {req_page, cand_off, {LINE_W{1'b0}}};
    end

    pfx_stream_table #(
        .N_STREAMS(N_STREAMS), .TAG_W(TAG_W), .OFF_W(OFF_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
        .nxt_last(nxt_last), .nxt_dir(nxt_dir), .nxt_run(nxt_run),
        .mark(accept), .mark_off(cand_off),
        .hit(hit), .sel_last(sel_last), .sel_dir(sel_dir),
        .sel_run(sel_run), .sel_bits(sel_bits)
    );

    pfx_step_eval #(.OFF_W(OFF_W), .DIST(DIST)) u_eval (
        .hit(req_valid && hit), .ent_last(sel_last), .ent_dir(sel_dir),
        .ent_run(sel_run), .ent_bits(sel_bits), .req_off(req_off),
        .nxt_last(nxt_last), .nxt_dir(nxt_dir), .nxt_run(nxt_run),
        .cand_valid(cand_valid), .cand_off(cand_off)
    );

    pfx_issue_slot #(.ADDR_W(ADDR_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_addr(cand_addr),
        .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr), .accept(accept)
    );

    // An accepted prefetch stays in the triggering page.
    assert_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pf_addr[ADDR_W-1:PAGE_W] == $past(req_addr[ADDR_W-1:PAGE_W])));

    // An accepted prefetch sits DIST lines from the triggering line.
    assert_distance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((pf_addr[ADDR_W-1:LINE_W] == $past(req_addr[ADDR_W-1:LINE_W]) + LN_W'(DIST)) ||
                    (pf_addr[ADDR_W-1:LINE_W] == $past(req_addr[ADDR_W-1:LINE_W]) - LN_W'(DIST))));

    // Nothing appears without a request.
    assert_no_unprompted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && (!pf_valid || pf_ready)) |=> !pf_valid);

    // An untracked page never yields a candidate.
    assert_new_page_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |-> !cand_valid);

    // Offered addresses are line aligned.
    assert_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[LINE_W-1:0] == '0));
endmodule

// File: tb/tb_pfx_stream_prefetcher.sv
module tb_pfx_stream_prefetcher;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        pf_ready;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pfx_stream_prefetcher dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    // Expected-value model built from the requirements.
    bit        mv    [4];
    bit [19:0] mpage [4];
    int        mlast [4];
    int        mdir  [4];
    int        mrun  [4];
    bit [63:0] mbits [4];
    int        mptr;
    bit        mpv;
    bit [31:0] mpa;

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            mv[i] = 0; mpage[i] = '0; mlast[i] = 0; mdir[i] = 1; mrun[i] = 0; mbits[i] = '0;
        end
        mptr = 0; mpv = 0; mpa = '0;
    endtask

    task automatic model_step(bit v, bit [31:0] a, bit rdy);
        int h = -1; int off; int d; int t = 0; bit cv = 0; bit [31:0] ca = '0;
        if (v) begin
            off = int'(a[11:6]);
            for (int i = 0; i < 4; i++) if (mv[i] && mpage[i] == a[31:12]) h = i;
            if (h < 0) begin
                mv[mptr] = 1; mpage[mptr] = a[31:12]; mlast[mptr] = off;
                mdir[mptr] = 1; mrun[mptr] = 0; mbits[mptr] = '0;
                mptr = (mptr + 1) % 4;
            end else if (off == mlast[h]) begin
                // repeat of latest line: no change (R10)
            end else if (off == mlast[h] + 1 || off == mlast[h] - 1) begin
                d = (off > mlast[h]) ? 1 : -1;
                mrun[h] = (mrun[h] > 0 && mdir[h] == d) ? 2 : 1;
                mdir[h] = d; mlast[h] = off;
                if (mrun[h] == 2) begin
                    t = off + 2 * d;
                    if (t >= 0 && t < 64 && !mbits[h][t]) begin
                        cv = 1; ca = {a[31:12], 6'(t), 6'b0};
                    end
                end
            end else begin
                mrun[h] = 0; mlast[h] = off;
            end
        end
        if (mpv && rdy) mpv = 0;
        if (cv && !mpv) begin mpv = 1; mpa = ca; mbits[h][t] = 1'b1; end
    endtask

    task automatic cyc(bit v, bit [31:0] a, bit rdy);
        @(negedge clk);
        req_valid = v; req_addr = a; pf_ready = rdy;
        if (rst_n) model_step(v, a, rdy);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; pf_ready = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic chk_none(string tag);
        checks++;
        if (pf_valid !== 1'b0) begin
            bad++;
            $display("FAIL %s: pf_valid=%b addr=%h expected pf_valid=0", tag, pf_valid, pf_addr);
        end
    endtask

    task automatic chk_pf(string tag, bit [31:0] exp);
        checks++;
        if (pf_valid !== 1'b1 || pf_addr !== exp) begin
            bad++;
            $display("FAIL %s: pf_valid=%b addr=%h expected pf_valid=1 addr=%h",
                     tag, pf_valid, pf_addr, exp);
        end
    endtask

    function automatic bit [31:0] la(int page, int line);
        return {page[19:0], line[5:0], 6'b0};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        int page_cur [6]; int pdir [6]; int pi; int r; bit v; bit rdy; int step;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; pf_ready = 1'b1;
        r = int'($urandom(32'd24681));

        // R1: reset state
        do_reset();
        #1; chk_none("R1 reset");
        cyc(1, la(5, 3), 1); chk_none("R1 first request");

        // R2: ascending run 3,4,5 -> line 7
        cyc(1, la(5, 4), 1); chk_none("R4 one step only");
        cyc(1, la(5, 5), 1); chk_pf("R2 ascending", la(5, 7));
        cyc(0, '0, 1);       chk_none("R9 drained");

        // R3: descending run 20,19,18 -> line 16
        cyc(1, la(9, 20), 1); cyc(1, la(9, 19), 1);
        cyc(1, la(9, 18), 1); chk_pf("R3 descending", la(9, 16));

        // R10: repeat of latest line
        do_reset();
        cyc(1, la(2, 10), 1); cyc(1, la(2, 11), 1);
        cyc(1, la(2, 11), 1); chk_none("R10 repeat no prefetch");
        cyc(1, la(2, 12), 1); chk_pf("R10 run kept", la(2, 14));

        // R7: rerun the same lines; line 14 already issued
        cyc(1, la(2, 10), 1); cyc(1, la(2, 11), 1);
        cyc(1, la(2, 12), 1); chk_none("R7 duplicate suppressed");

        // R5: page top edge
        do_reset();
        cyc(1, la(3, 59), 1); cyc(1, la(3, 60), 1);
        cyc(1, la(3, 61), 1); chk_pf("R5 last line allowed", la(3, 63));
        cyc(1, la(3, 62), 1); chk_none("R5 target past page top");
        cyc(1, la(3, 63), 1); chk_none("R5 target past page top 2");
        // R6: crossing into page 4
        cyc(1, la(4, 0), 1);  chk_none("R6 new page first");
        cyc(1, la(4, 1), 1);  chk_none("R6 new page second");
        cyc(1, la(4, 2), 1);  chk_pf("R6 new page run", la(4, 4));
        // R5: page bottom edge, descending
        cyc(1, la(8, 4), 1); cyc(1, la(8, 3), 1);
        cyc(1, la(8, 2), 1); chk_pf("R5 first line allowed", la(8, 0));
        cyc(1, la(8, 1), 1); chk_none("R5 target below page");

        // R4: non-unit strides
        do_reset();
        cyc(1, la(6, 0), 1); cyc(1, la(6, 2), 1);
        cyc(1, la(6, 4), 1); chk_none("R4 stride two");
        cyc(1, la(6, 5), 1); chk_none("R4 restart step");
        cyc(1, la(6, 6), 1); chk_pf("R4 rerun confirmed", la(6, 8));
        cyc(1, la(6, 5), 1); chk_none("R4 reversal breaks run");

        // R8: replacement of oldest allocation
        do_reset();
        for (int p = 1; p <= 4; p++) begin
            cyc(1, la(p, 10), 1); cyc(1, la(p, 11), 1);
        end
        cyc(1, la(5, 0), 1);  chk_none("R8 fifth page allocates");
        cyc(1, la(1, 12), 1); chk_none("R8 evicted page lost run");
        cyc(1, la(3, 12), 1); chk_pf("R8 surviving page", la(3, 14));

        // R9: backpressure
        do_reset();
        cyc(1, la(7, 0), 0); cyc(1, la(7, 1), 0);
        cyc(1, la(7, 2), 0); chk_pf("R9 offered", la(7, 4));
        cyc(1, la(7, 3), 0); chk_pf("R9 held, newer dropped", la(7, 4));
        cyc(0, '0, 0);       chk_pf("R9 still held", la(7, 4));
        cyc(0, '0, 1);       chk_none("R9 drained");
        cyc(1, la(7, 4), 1); chk_pf("R9 next after drain", la(7, 6));

        // Random phase against the model (R2, R3, R9, R11)
        do_reset();
        for (int i = 0; i < 6; i++) begin
            page_cur[i] = int'($urandom % 64); pdir[i] = ($urandom % 2) ? 1 : -1;
        end
        pi = 0;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 8 == 0) pi = int'($urandom % 6);
            step = int'($urandom % 20);
            if (step < 14)      page_cur[pi] += pdir[pi];
            else if (step < 16) ;
            else if (step < 17) begin pdir[pi] = -pdir[pi]; page_cur[pi] += pdir[pi]; end
            else                page_cur[pi] = int'($urandom % 64);
            page_cur[pi] = (page_cur[pi] + 64) % 64;
            v   = ($urandom % 5) != 0;
            rdy = ($urandom % 4) != 0;
            cyc(v, la(16 + pi, page_cur[pi]), rdy);
            checks++;
            if (pf_valid !== mpv || (mpv && pf_addr !== mpa) || (pf_valid && pf_addr[5:0] != 6'd0)) begin
                bad++;
                $display("FAIL R2/R9/R11 random cycle %0d: valid=%b addr=%h expected valid=%b addr=%h",
                         n, pf_valid, pf_addr, mpv, mpa);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule